// File: doc/BRIEF.md
# Byte-Wide ADC Conversion Sequencer

This block runs a successive-approximation analog-to-digital converter whose result bus is only eight bits wide. It produces the converter's enable, active-low select, read/convert, resolution-select and byte-select control levels directly from a small state machine. Each pass through the machine starts one full-resolution conversion and waits for the converter's busy line to drop. It then reads the 12-bit result in two byte reads, high byte first and low nibble second, and joins the two parts into one 12-bit sample.

Each sample is written into a 64-entry dual-port buffer at the current write address. On the cycle after the write, a 6-bit write-address counter advances. The counter wraps from 63 to 0 without stalling and flags the wrap for one cycle. The counter can be cleared synchronously at any time. A host reads the buffer through a separate read address, and the read data is registered. The machine loops without pause, so samples are taken back to back for as long as the converter keeps finishing.

The states, in the order they are visited, are:

| State | Length | Leaves to | Condition |
|---|---|---|---|
| ST_IDLE | one cycle | ST_START | always |
| ST_START | one cycle | ST_WAIT | always |
| ST_WAIT | until busy is sampled 0 | ST_HI | busy sampled 0 |
| ST_HI | one cycle | ST_LO | always |
| ST_LO | one cycle | ST_COMMIT | always |
| ST_COMMIT | one cycle | ST_BUMP | always |
| ST_BUMP | one cycle | ST_IDLE | always |

Any state encoding outside this list goes to ST_IDLE on the next clock.

Top module: `adc_byte_sequencer`

## Requirements
- R1: In idle, and while reset is held, the control outputs are conv_ce=0, conv_cs_n=1, conv_rc=1, conv_a0=0, and the converter is disabled.
- R2: On the cycle after idle, a start step lasts exactly one cycle with conv_ce=1, conv_cs_n=0, conv_rc=0 and conv_a0=0. conv_a0=0 selects a full 12-bit conversion.
- R3: After the start step, the block holds conv_ce=1, conv_cs_n=0, conv_rc=1, conv_a0=0 for as long as conv_busy is sampled 1. It leaves on the first clock edge at which conv_busy is 0.
- R4: The cycle after the wait is the high-byte read step (conv_ce=1, conv_cs_n=0, conv_rc=1, conv_a0=0). conv_data[7:0] from this step becomes bits [11:4] of the sample.
- R5: The next cycle is the low-nibble read step, with conv_a0=1 and the other pins as in R4. conv_data[7:4] becomes sample bits [3:0], and conv_data[3:0] is ignored.
- R6: conv_mode12 is 0 at all times, so every read uses the byte-wise output mode.
- R7: buf_we is high for exactly one cycle, the cycle after the low-nibble step. In that cycle the sample {high byte, low nibble} is written at the current wr_addr.
- R8: wr_addr increments by one on the clock edge that ends the cycle after the write pulse. The written sample therefore sits at the address that was current before the increment.
- R9: When an increment takes wr_addr from 63, it becomes 0 and wr_wrap is 1 for exactly that advance cycle. wr_wrap is 0 in every other cycle.
- R10: cnt_clr=1 forces wr_addr to 0 at the next clock edge. It wins over a coincident increment, and it suppresses wr_wrap in that cycle.
- R11: rd_data shows the buffer entry at rd_addr one clock after rd_addr is applied. A read of the address being written in the same cycle returns the previous contents.
- R12: Asserting rst_n low immediately returns the pins to the idle levels and sets wr_addr to 0. After release, the block starts from idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cnt_clr | input | 1 | Synchronous clear of the write-address counter |
| conv_busy | input | 1 | Converter busy status, high while a conversion is in progress |
| conv_data | input | 8 | Converter output byte |
| conv_ce | output | 1 | Converter chip enable |
| conv_cs_n | output | 1 | Converter select, active low |
| conv_rc | output | 1 | Read (1) or convert (0) |
| conv_mode12 | output | 1 | Resolution/output-mode select, held 0 |
| conv_a0 | output | 1 | Byte select: 0 selects the high byte, 1 selects the low nibble |
| rd_addr | input | 6 | Host read address |
| rd_data | output | 12 | Registered host read data |
| buf_we | output | 1 | Buffer write pulse |
| wr_addr | output | 6 | Current write address |
| wr_wrap | output | 1 | One-cycle flag when wr_addr wraps from 63 to 0 |

## Verification
Two pairs of functions can fall in the same cycle.

- Counter clear and advance: the bench raises cnt_clr during the advance step, once at an ordinary address and once at address 63. It then expects wr_addr to read 0 after that edge and wr_wrap to stay low in that cycle.
- Host read and buffer write: during every write pulse, the bench points rd_addr at the address being written. Once an address has been written before, it expects the old contents on the following cycle and the new sample one cycle later.

Busy lengths, sample values and the ignored low bits of the low-nibble byte are drawn at random. A final pass reads back the whole buffer while the machine is parked in the wait state.

// File: rtl/adcseq_pkg.sv
package adcseq_pkg;

    // Sequencer states; the numeric order is the visiting order.
    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_START  = 3'd1,
        ST_WAIT   = 3'd2,
        ST_HI     = 3'd3,
        ST_LO     = 3'd4,
        ST_COMMIT = 3'd5,
        ST_BUMP   = 3'd6
    } seq_state_e;

    // One set of converter control levels.
    typedef struct packed {
        logic ce;
        logic cs_n;
        logic rc;
        logic a0;
    } pin_set_t;

    localparam pin_set_t PINS_OFF   = '{ce: 1'b0, cs_n: 1'b1, rc: 1'b1, a0: 1'b0};
    localparam pin_set_t PINS_CONV  = '{ce: 1'b1, cs_n: 1'b0, rc: 1'b0, a0: 1'b0};
    localparam pin_set_t PINS_RD_HI = '{ce: 1'b1, cs_n: 1'b0, rc: 1'b1, a0: 1'b0};
    localparam pin_set_t PINS_RD_LO = '{ce: 1'b1, cs_n: 1'b0, rc: 1'b1, a0: 1'b1};

endpackage

// File: rtl/adcseq_fsm.sv
module adcseq_fsm
    import adcseq_pkg::*;
#(
    parameter int BUS_W    = 8,
    parameter int SAMPLE_W = 12
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                busy_i,
    input  logic [BUS_W-1:0]    bus_i,
    output logic                ce_o,
    output logic                cs_n_o,
    output logic                rc_o,
    output logic                a0_o,
    output logic                mode12_o,
    output logic                we_o,
    output logic                adv_o,
    output logic [SAMPLE_W-1:0] sample_o
);

    // Width of the trailing part that arrives in the second byte read.
    localparam int LO_W = SAMPLE_W - BUS_W;

    seq_state_e state_q;
    seq_state_e state_n;
    pin_set_t   pins;

    logic [BUS_W-1:0] hi_q;
    logic [LO_W-1:0]  lo_q;

    // State register, asynchronous reset to idle.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_n;
        end
    end

    // Transition logic.
    always_comb begin
        state_n = state_q;
        unique case (state_q)
            ST_IDLE:   state_n = ST_START;
            ST_START:  state_n = ST_WAIT;
            ST_WAIT:   state_n = busy_i ? ST_WAIT : ST_HI;
            ST_HI:     state_n = ST_LO;
            ST_LO:     state_n = ST_COMMIT;
            ST_COMMIT: state_n = ST_BUMP;
            ST_BUMP:   state_n = ST_IDLE;
            default:   state_n = ST_IDLE;
        endcase
    end

    // Output decode (Moore).
    always_comb begin
        pins  = PINS_OFF;
        we_o  = 1'b0;
        adv_o = 1'b0;
        unique case (state_q)
            ST_IDLE:   pins = PINS_OFF;
            ST_START:  pins = PINS_CONV;
            ST_WAIT:   pins = PINS_RD_HI;
            ST_HI:     pins = PINS_RD_HI;
            ST_LO:     pins = PINS_RD_LO;
            ST_COMMIT: we_o = 1'b1;
            ST_BUMP:   adv_o = 1'b1;
            default:   pins = PINS_OFF;
        endcase
    end

    assign ce_o     = pins.ce;
    assign cs_n_o   = pins.cs_n;
    assign rc_o     = pins.rc;
    assign a0_o     = pins.a0;
    assign mode12_o = 1'b0;

    // Byte capture: whole bus as the upper part, then the top LO_W bits of
    // the second byte as the lower part; the remaining bits are dropped.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hi_q <= '0;
            lo_q <= '0;
        end else begin
            if (state_q == ST_HI) begin
                hi_q <= bus_i;
            end
            if (state_q == ST_LO) begin
                lo_q <= bus_i[BUS_W-1 -: LO_W];
            end
        end
    end

    assign sample_o = {hi_q, lo_q};

    // R2
    start_one_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!rc_o) |=> rc_o);

    // R3
    wait_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_WAIT && busy_i) |=> (state_q == ST_WAIT));

    // R5
    lo_follows_hi_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_HI) |=> a0_o);

    // R7
    we_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        we_o |=> !we_o);

endmodule

// File: rtl/adcseq_addr_ctr.sv
module adcseq_addr_ctr #(
    parameter int ADDR_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr_i,
    input  logic              inc_i,
    output logic [ADDR_W-1:0] count_o,
    output logic              wrap_o
);

    localparam logic [ADDR_W-1:0] TOP = {ADDR_W{1'b1}};

    logic [ADDR_W-1:0] count_q;

    // Clear has priority over increment; the counter rolls over freely.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            count_q <= '0;
        end else if (clr_i) begin
            count_q <= '0;
        end else if (inc_i) begin
            count_q <= count_q + ADDR_W'(1);
        end
    end

    assign count_o = count_q;
    assign wrap_o  = inc_i && !clr_i && (count_q == TOP);

    // R8
    advance_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (inc_i && !clr_i) |=> (count_q == $past(count_q) + ADDR_W'(1)));

    // R10
    clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |=> (count_q == '0));

    // R9
    wrap_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wrap_o |=> (count_q == '0));

endmodule

// File: rtl/adcseq_sample_buf.sv
module adcseq_sample_buf #(
    parameter int WORD_W = 12,
    parameter int ADDR_W = 6
) (
    input  logic              clk,
    input  logic              we_i,
    input  logic [ADDR_W-1:0] waddr_i,
    input  logic [WORD_W-1:0] wdata_i,
    input  logic [ADDR_W-1:0] raddr_i,
    output logic [WORD_W-1:0] rdata_o
);

    localparam int DEPTH = 1 << ADDR_W;

    logic [WORD_W-1:0] mem [DEPTH];
    logic [WORD_W-1:0] rdata_q;

    // Registered read; a same-address write lands after the read samples.
    always_ff @(posedge clk) begin
        if (we_i) begin
            mem[waddr_i] <= wdata_i;
        end
        rdata_q <= mem[raddr_i];
    end

    assign rdata_o = rdata_q;

endmodule

// File: rtl/adc_byte_sequencer.sv
module adc_byte_sequencer #(
    parameter int BUS_W    = 8,
    parameter int SAMPLE_W = 12,
    parameter int ADDR_W   = 6
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cnt_clr,
    input  logic                conv_busy,
    input  logic [BUS_W-1:0]    conv_data,
    output logic                conv_ce,
    output logic                conv_cs_n,
    output logic                conv_rc,
    output logic                conv_mode12,
    output logic                conv_a0,
    input  logic [ADDR_W-1:0]   rd_addr,
    output logic [SAMPLE_W-1:0] rd_data,
    output logic                buf_we,
    output logic [ADDR_W-1:0]   wr_addr,
    output logic                wr_wrap
);

    logic                we;
    logic                adv;
    logic [SAMPLE_W-1:0] sample;
    logic [ADDR_W-1:0]   waddr;

    adcseq_fsm #(
        .BUS_W    (BUS_W),
        .SAMPLE_W (SAMPLE_W)
    ) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .busy_i   (conv_busy),
        .bus_i    (conv_data),
        .ce_o     (conv_ce),
        .cs_n_o   (conv_cs_n),
        .rc_o     (conv_rc),
        .a0_o     (conv_a0),
        .mode12_o (conv_mode12),
        .we_o     (we),
        .adv_o    (adv),
        .sample_o (sample)
    );

    adcseq_addr_ctr #(
        .ADDR_W (ADDR_W)
    ) u_ctr (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr_i   (cnt_clr),
        .inc_i   (adv),
        .count_o (waddr),
        .wrap_o  (wr_wrap)
    );

    adcseq_sample_buf #(
        .WORD_W (SAMPLE_W),
        .ADDR_W (ADDR_W)
    ) u_buf (
        .clk     (clk),
        .we_i    (we),
        .waddr_i (waddr),
        .wdata_i (sample),
        .raddr_i (rd_addr),
        .rdata_o (rd_data)
    );

    assign buf_we  = we;
    assign wr_addr = waddr;

endmodule

// File: tb/sim_adc_byte_sequencer.sv
`timescale 1ns/1ps
module sim_adc_byte_sequencer;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cnt_clr = 1'b0;
    logic        conv_busy = 1'b0;
    logic [7:0]  conv_data;
    logic        conv_ce, conv_cs_n, conv_rc, conv_mode12, conv_a0;
    logic [5:0]  rd_addr = '0;
    logic [11:0] rd_data;
    logic        buf_we;
    logic [5:0]  wr_addr;
    logic        wr_wrap;

    // Converter model state
    logic [7:0]  m_hi = 8'h00;
    logic [3:0]  m_lo = 4'h0;
    logic [3:0]  m_junk = 4'h0;
    logic [7:0]  m_idle = 8'h00;

    int          checks = 0;
    int          failures = 0;
    int          cyc = 0;
    logic [5:0]  exp_addr = '0;
    logic [11:0] shadow [64];
    bit          written [64];
    logic [11:0] pend_word = '0;
    bit          pend_valid = 1'b0;

    always #10 clk = ~clk;

    // Byte presented by the converter: high byte when a0=0, low nibble with
    // nonzero trailing bits when a0=1, unrelated value when not reading.
    assign conv_data = (conv_ce && !conv_cs_n && conv_rc) ?
                       (conv_a0 ? {m_lo, m_junk} : m_hi) : m_idle;

    adc_byte_sequencer u0 (
        .clk         (clk),
        .rst_n       (rst_n),
        .cnt_clr     (cnt_clr),
        .conv_busy   (conv_busy),
        .conv_data   (conv_data),
        .conv_ce     (conv_ce),
        .conv_cs_n   (conv_cs_n),
        .conv_rc     (conv_rc),
        .conv_mode12 (conv_mode12),
        .conv_a0     (conv_a0),
        .rd_addr     (rd_addr),
        .rd_data     (rd_data),
        .buf_we      (buf_we),
        .wr_addr     (wr_addr),
        .wr_wrap     (wr_wrap)
    );

    function automatic logic [11:0] pack_word(input logic [7:0] hi, input logic [3:0] lo);
        return {hi, lo};
    endfunction

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic chk_pins(input string req, input bit ce, input bit cs_n, input bit rc, input bit a0);
        chk({conv_ce, conv_cs_n, conv_rc, conv_a0} == {ce, cs_n, rc, a0}, req,
            {conv_ce, conv_cs_n, conv_rc, conv_a0}, {ce, cs_n, rc, a0});
        chk(conv_mode12 == 1'b0, "R6 mode pin", conv_mode12, 0);
    endtask

    task automatic check_pending();
        if (pend_valid) begin
            chk(rd_data == pend_word, "R4 R5 R7 stored sample", rd_data, pend_word);
        end
        pend_valid = 1'b0;
    endtask

    // Entered and left at the negedge of an idle cycle.
    task automatic do_sample(input int n_busy, input bit clr_at_bump);
        logic [7:0]  hi;
        logic [3:0]  lo;
        logic [11:0] word;
        logic [11:0] old;
        bit          had;
        bit          wrapped;
        hi     = 8'($urandom);
        lo     = 4'($urandom);
        m_hi   = hi;
        m_lo   = lo;
        m_junk = 4'($urandom) | 4'h1;
        m_idle = 8'($urandom);
        chk_pins("R1 idle", 0, 1, 1, 0);
        chk(wr_wrap == 1'b0, "R9 no wrap in idle", wr_wrap, 0);
        @(negedge clk);
        check_pending();
        chk_pins("R2 start", 1, 0, 0, 0);
        conv_busy = 1'b1;
        for (int i = 0; i < n_busy; i++) begin
            @(negedge clk);
            chk_pins("R3 wait", 1, 0, 1, 0);
            if (i == n_busy - 1) conv_busy = 1'b0;
        end
        @(negedge clk);
        chk_pins("R4 high read", 1, 0, 1, 0);
        chk(buf_we == 1'b0, "R7 no early write", buf_we, 0);
        @(negedge clk);
        chk_pins("R5 low read", 1, 0, 1, 1);
        @(negedge clk);
        chk(buf_we == 1'b1, "R7 write pulse", buf_we, 1);
        chk(wr_addr == exp_addr, "R8 write address", wr_addr, exp_addr);
        word = pack_word(hi, lo);
        rd_addr = exp_addr;
        old = shadow[exp_addr];
        had = written[exp_addr];
        shadow[exp_addr] = word;
        written[exp_addr] = 1'b1;
        @(negedge clk);
        chk(buf_we == 1'b0, "R7 pulse one cycle", buf_we, 0);
        chk(wr_addr == exp_addr, "R8 not yet advanced", wr_addr, exp_addr);
        if (had) chk(rd_data == old, "R11 read-before-write", rd_data, old);
        if (clr_at_bump) cnt_clr = 1'b1;
        #1;
        wrapped = !clr_at_bump && (exp_addr == 6'd63);
        chk(wr_wrap == wrapped, clr_at_bump ? "R10 wrap suppressed" : "R9 wrap flag", wr_wrap, wrapped);
        @(negedge clk);
        cnt_clr = 1'b0;
        exp_addr = clr_at_bump ? 6'd0 : exp_addr + 6'd1;
        chk(wr_addr == exp_addr, clr_at_bump ? "R10 clear wins" : (wrapped ? "R9 wrap to zero" : "R8 advance"),
            wr_addr, exp_addr);
        pend_word  = word;
        pend_valid = 1'b1;
    endtask

    task automatic finish_run();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    // Watchdog
    always @(posedge clk) begin
        cyc++;
        if (cyc >= 150000) begin
            failures++;
            $display("FAIL watchdog all-requirements actual=%0d expected<%0d", cyc, 150000);
            finish_run();
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        for (int a = 0; a < 64; a++) begin
            written[a] = 1'b0;
            shadow[a]  = '0;
        end
        repeat (3) @(negedge clk);
        chk_pins("R1 reset pins", 0, 1, 1, 0);
        chk(wr_addr == 6'd0, "R1 reset address", wr_addr, 0);
        chk(buf_we == 1'b0, "R1 reset write", buf_we, 0);
        rst_n = 1'b1;

        // First lap: fill the buffer, wrap at the 64th sample.
        for (int i = 0; i < 64; i++) do_sample(1 + int'($urandom % 6), 1'b0);
        // A few more, with a clear at an ordinary address.
        for (int i = 0; i < 6; i++) do_sample(1 + int'($urandom % 4), i == 3);

        // Asynchronous reset in the middle of a wait (R12).
        @(negedge clk);
        check_pending();
        conv_busy = 1'b1;
        @(negedge clk);
        chk_pins("R3 wait before reset", 1, 0, 1, 0);
        rst_n = 1'b0;
        #1;
        chk_pins("R12 async reset pins", 0, 1, 1, 0);
        chk(wr_addr == 6'd0, "R12 async reset address", wr_addr, 0);
        @(negedge clk);
        rst_n = 1'b1;
        conv_busy = 1'b0;
        exp_addr = '0;

        // Second lap: collisions on every write; clear coincides with wrap.
        for (int i = 0; i < 64; i++) do_sample(1 + int'($urandom % 5), i == 63);

        // Park in wait and read the whole buffer back.
        conv_busy = 1'b1;
        @(negedge clk);
        check_pending();
        @(negedge clk);
        for (int a = 0; a < 64; a++) begin
            rd_addr = 6'(a);
            @(negedge clk);
            chk_pins("R3 parked", 1, 0, 1, 0);
            if (written[a]) chk(rd_data == shadow[a], "R11 readback", rd_data, shadow[a]);
        end
        finish_run();
    end

endmodule